// File: doc/BRIEF.md
# Dual-Master Interrupt Mask Logic

This block drives one active-low interrupt line for each of two upstream masters that share a downstream bus through a selector. Each master owns a private four-bit mask register. Both masters write it at the same register index, and the block keeps one physical copy per master. A mask bit at 0 lets its event pull the master's line low. A mask bit at 1 blocks it.

Four event sources feed per-master sticky flags:
- the peer master lost its connection;
- the downstream bus was busy at the moment of switching, for a connection requested without bus initialization;
- bus initialization completed, for a connection requested with it;
- an external active-low interrupt input went low.

A masked event still records its flag. A per-master strobe clears all four of that master's flags.

Each master also has a control register with a bus-init request bit and two test bits. One test bit forces the master's own line low and the other forces the peer's line low. The register-access front end is outside this block: it delivers decoded write strobes and data for each master.

Top module: `dual_irq_mask`

## Requirements
- R1: After reset, all mask bits, flags and control bits are 0 and both interrupt outputs are high.
- R2: A mask write by master m updates only copy m. Readback bits [3:0] hold the written bits and bits [7:4] read 0 whatever was written.
- R3: With mask bit k at 0, a set flag k pulls that master's line low. With mask bit k at 1, the line stays high. Bit positions are: 3 peer-lost, 2 busy-at-switch, 1 init-done, 0 external input.
- R4: A masked event still sets its flag. The flags are read back at the same bit positions, with master m in bits [4m+3:4m].
- R5: The busy-at-switch flag sets only when that master's control bit 4 (init request) is 0.
- R6: The init-done flag sets only when that master's control bit 4 is 1.
- R7: The external input held low sets flag 0 of both masters.
- R8: A clear strobe empties that master's flags on the next edge. An event arriving in the same cycle still sets its flag.
- R9: Control bit 6 at 1 forces the writer's own line low, and control bit 7 at 1 forces the peer's line low, regardless of masks. Writing 0 to either bit releases its line.
- R10: A peer-lost event sets flag 3 of the receiving master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ie_we_i | input | 2 | Mask register write strobe, one bit per master |
| ctrl_we_i | input | 2 | Control register write strobe, one bit per master |
| wdata_i | input | 16 | Write data, master m in bits [8m+7:8m] |
| clr_i | input | 2 | Flag clear strobe, one bit per master |
| bus_lost_i | input | 2 | Peer-disconnected event, per receiving master |
| sw_busy_i | input | 2 | Bus busy at switching moment, per requesting master |
| init_done_i | input | 2 | Bus initialization finished, per requesting master |
| ext_int_ni | input | 1 | External interrupt input, active low |
| ie_rdata_o | output | 16 | Mask register readback, master m in bits [8m+7:8m] |
| flags_o | output | 8 | Sticky event flags, master m in bits [4m+3:4m] |
| int_no | output | 2 | Interrupt line per master, active low |

## Verification
The hardest states to reach are the two event gates, which depend on a control bit written in an earlier cycle. The bench first writes the init-request bit and only then fires the opposite event, so that the flag must stay clear. The case of a clear and an event in the same cycle is built by raising both strobes on one edge. Cross-master forcing is shown by writing the peer test bit from each side while every mask is set, so that only the test path can pull the line low.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
  localparam int NUM_MST = 2;
  localparam int NUM_EVT = 4;
  localparam int REG_W   = 8;
  // event / mask bit positions
  localparam int EV_EXT  = 0;
  localparam int EV_INIT = 1;
  localparam int EV_BUSY = 2;
  localparam int EV_LOST = 3;
  // control bit positions
  localparam int CTL_INIT = 4;
  localparam int CTL_OWN  = 6;
  localparam int CTL_PEER = 7;
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int REG_W = 8,
  parameter int EVT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [EVT_W-1:0] mask_o,
  output logic [REG_W-1:0] rdata_o
);
  logic [EVT_W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '0;
    else if (we_i) mask_q <= wdata_i[EVT_W-1:0];
  end

  assign mask_o  = mask_q;
  assign rdata_o = {{(REG_W-EVT_W){1'b0}}, mask_q};

  // R2: bank isolation, copy only moves on its own strobe
  a_r2_hold_no_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mask_o));
  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mask_o == $past(wdata_i[EVT_W-1:0]));
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
  import irq_mask_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic             init_req_o,
  output logic             test_own_o,
  output logic             test_peer_o
);
  logic init_q, own_q, peer_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b0;
      own_q  <= 1'b0;
      peer_q <= 1'b0;
    end else if (we_i) begin
      init_q <= wdata_i[CTL_INIT];
      own_q  <= wdata_i[CTL_OWN];
      peer_q <= wdata_i[CTL_PEER];
    end
  end

  assign init_req_o  = init_q;
  assign test_own_o  = own_q;
  assign test_peer_o = peer_q;
endmodule

// File: rtl/irq_event_flags.sv
module irq_event_flags
  import irq_mask_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               lost_i,
  input  logic               busy_i,
  input  logic               init_done_i,
  input  logic               ext_act_i,
  input  logic               init_req_i,
  output logic [NUM_EVT-1:0] flags_o
);
  logic [NUM_EVT-1:0] set_d, flg_q;

  always_comb begin
    set_d          = '0;
    set_d[EV_EXT]  = ext_act_i;
    set_d[EV_INIT] = init_done_i & init_req_i;
    set_d[EV_BUSY] = busy_i & ~init_req_i;
    set_d[EV_LOST] = lost_i;
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flg_q <= '0;
    else if (clr_i)  flg_q <= set_d;
    else             flg_q <= flg_q | set_d;
  end

  assign flags_o = flg_q;

  a_r8_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !lost_i && !busy_i && !init_done_i && !ext_act_i |=> flags_o == '0);
  a_r4_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (flags_o & $past(flags_o)) == $past(flags_o));
  a_r5_busy_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[EV_BUSY]) |-> $past(busy_i && !init_req_i));
  a_r6_init_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[EV_INIT]) |-> $past(init_done_i && init_req_i));
endmodule

// File: rtl/dual_irq_mask.sv
module dual_irq_mask
  import irq_mask_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_MST-1:0]       ie_we_i,
  input  logic [NUM_MST-1:0]       ctrl_we_i,
  input  logic [NUM_MST*REG_W-1:0] wdata_i,
  input  logic [NUM_MST-1:0]       clr_i,
  input  logic [NUM_MST-1:0]       bus_lost_i,
  input  logic [NUM_MST-1:0]       sw_busy_i,
  input  logic [NUM_MST-1:0]       init_done_i,
  input  logic                     ext_int_ni,
  output logic [NUM_MST*REG_W-1:0] ie_rdata_o,
  output logic [NUM_MST*NUM_EVT-1:0] flags_o,
  output logic [NUM_MST-1:0]       int_no
);
  logic [NUM_EVT-1:0] mask_w [NUM_MST];
  logic [NUM_EVT-1:0] flg_w  [NUM_MST];
  logic [NUM_MST-1:0] init_req_w, own_w, peer_w;
  logic               ext_act;

  assign ext_act = ~ext_int_ni;

  for (genvar m = 0; m < NUM_MST; m++) begin : g_mst
    localparam int PEER = NUM_MST - 1 - m;

    irq_mask_reg #(.REG_W(REG_W), .EVT_W(NUM_EVT)) u_mask (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (ie_we_i[m]),
      .wdata_i (wdata_i[m*REG_W +: REG_W]),
      .mask_o  (mask_w[m]),
      .rdata_o (ie_rdata_o[m*REG_W +: REG_W])
    );

    irq_ctrl_reg #(.REG_W(REG_W)) u_ctrl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .we_i        (ctrl_we_i[m]),
      .wdata_i     (wdata_i[m*REG_W +: REG_W]),
      .init_req_o  (init_req_w[m]),
      .test_own_o  (own_w[m]),
      .test_peer_o (peer_w[m])
    );

    irq_event_flags u_flags (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clr_i       (clr_i[m]),
      .lost_i      (bus_lost_i[m]),
      .busy_i      (sw_busy_i[m]),
      .init_done_i (init_done_i[m]),
      .ext_act_i   (ext_act),
      .init_req_i  (init_req_w[m]),
      .flags_o     (flg_w[m])
    );

    assign flags_o[m*NUM_EVT +: NUM_EVT] = flg_w[m];
    assign int_no[m] = ~((|(flg_w[m] & ~mask_w[m])) | own_w[m] | peer_w[PEER]);

    // R9: peer test bit written by the other master forces this line
    a_r9_peer_force: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl_we_i[PEER] && wdata_i[PEER*REG_W + CTL_PEER] |=> !int_no[m]);
    a_r9_own_force: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl_we_i[m] && wdata_i[m*REG_W + CTL_OWN] |=> !int_no[m]);
    // R3: all masked and no test bits leaves the line high
    a_r3_all_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mask_w[m] == '1) && !own_w[m] && !peer_w[PEER] |-> int_no[m]);
  end
endmodule

// File: tb/dual_irq_mask_tb_top.sv
module dual_irq_mask_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ie_we = '0, ctrl_we = '0, clr = '0, lost = '0, busy = '0, idone = '0;
  logic [15:0] wdata = '0;
  logic        ext_n = 1'b1;
  logic [15:0] ie_rd;
  logic [7:0]  flg;
  logic [1:0]  irq_n;

  always #5 clk = ~clk;

  dual_irq_mask dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ie_we_i(ie_we), .ctrl_we_i(ctrl_we),
    .wdata_i(wdata), .clr_i(clr), .bus_lost_i(lost), .sw_busy_i(busy),
    .init_done_i(idone), .ext_int_ni(ext_n), .ie_rdata_o(ie_rd),
    .flags_o(flg), .int_no(irq_n)
  );

  typedef struct {
    logic [1:0]  irq;
    logic [7:0]  flg;
    logic [15:0] rd;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   vectors = 0, errors = 0;
  bit   done = 0;

  // reference state
  logic [3:0] m_mask [2];
  logic [3:0] m_flg  [2];
  logic       m_init [2];
  logic       m_own  [2];
  logic       m_peer [2];

  function automatic exp_t predict(string tag);
    exp_t e;
    for (int m = 0; m < 2; m++) begin
      e.irq[m] = ~((|(m_flg[m] & ~m_mask[m])) | m_own[m] | m_peer[1-m]);
      e.flg[m*4 +: 4] = m_flg[m];
      e.rd[m*8 +: 8]  = {4'h0, m_mask[m]};
    end
    e.tag = tag;
    return e;
  endfunction

  task automatic step(string tag);
    logic [3:0] set;
    logic [3:0] nflg [2];
    for (int m = 0; m < 2; m++) begin
      set = {lost[m], busy[m] & ~m_init[m], idone[m] & m_init[m], ~ext_n};
      nflg[m] = (clr[m] ? 4'h0 : m_flg[m]) | set;
    end
    for (int m = 0; m < 2; m++) begin
      m_flg[m] = nflg[m];
      if (ie_we[m]) m_mask[m] = wdata[m*8 +: 4];
      if (ctrl_we[m]) begin
        m_init[m] = wdata[m*8+4];
        m_own[m]  = wdata[m*8+6];
        m_peer[m] = wdata[m*8+7];
      end
    end
    @(posedge clk); #1;
    exp_q.push_back(predict(tag));
    ie_we = '0; ctrl_we = '0; clr = '0; lost = '0; busy = '0; idone = '0; ext_n = 1'b1;
  endtask

  task automatic wr_ie(int m, logic [7:0] d, string tag);
    ie_we[m] = 1'b1; wdata[m*8 +: 8] = d; step(tag);
  endtask

  task automatic wr_ctrl(int m, logic [7:0] d, string tag);
    ctrl_we[m] = 1'b1; wdata[m*8 +: 8] = d; step(tag);
  endtask

  // monitor: compare at negedge, well after the edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      vectors++;
      if (irq_n !== e.irq || flg !== e.flg || ie_rd !== e.rd) begin
        errors++;
        $display("FAIL %s: irq=%b flags=%h rd=%h, expected irq=%b flags=%h rd=%h",
                 e.tag, irq_n, flg, ie_rd, e.irq, e.flg, e.rd);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      m_mask[m] = '0; m_flg[m] = '0; m_init[m] = 0; m_own[m] = 0; m_peer[m] = 0;
    end
    #23 rst_n = 1'b1;
    #4;
    step("R1 reset defaults");

    // banked mask copies, upper bits read zero
    wr_ie(0, 8'hFF, "R2 bank0 write");
    wr_ie(1, 8'hA5, "R2 bank1 write");
    wr_ie(0, 8'h00, "R2 bank0 clear");
    wr_ie(1, 8'h00, "R2 bank1 clear");

    // each event against each mask setting, master 0
    for (int e = 0; e < 4; e++) begin
      for (int mk = 0; mk < 2; mk++) begin
        string tg;
        case (e)
          0: tg = "R7 ext event";
          1: tg = "R6 init-done event";
          2: tg = "R5 busy event";
          default: tg = "R10 peer-lost event";
        endcase
        tg = {tg, mk ? " masked R4" : " unmasked R3"};
        wr_ie(0, 8'(mk << e), "R2 mask setup");
        wr_ctrl(0, (e == 1) ? 8'h10 : 8'h00, "R6 init request setup");
        case (e)
          0: ext_n = 1'b0;
          1: idone[0] = 1'b1;
          2: busy[0] = 1'b1;
          default: lost[0] = 1'b1;
        endcase
        step(tg);
        clr = 2'b11; step("R8 clear both");
      end
    end
    wr_ie(0, 8'h00, "R2 mask reset");

    // gate checks
    wr_ctrl(1, 8'h10, "R6 init request m1");
    busy[1] = 1'b1; step("R5 busy blocked by init request");
    idone[1] = 1'b1; step("R6 init-done accepted");
    wr_ctrl(1, 8'h00, "R5 init request cleared m1");
    idone[1] = 1'b1; step("R6 init-done blocked without request");
    busy[1] = 1'b1; step("R5 busy accepted");
    clr[1] = 1'b1; step("R8 clear m1");

    // clear and event in same cycle
    lost[0] = 1'b1; step("R10 lost m0");
    clr[0] = 1'b1; busy[0] = 1'b1; step("R8 event wins over clear");
    clr[0] = 1'b1; step("R8 clear m0");

    // test forcing with all masked
    wr_ie(0, 8'h0F, "R3 mask all m0");
    wr_ie(1, 8'h0F, "R3 mask all m1");
    lost = 2'b11; step("R3 masked lost both");
    wr_ctrl(0, 8'h40, "R9 own force m0");
    wr_ctrl(0, 8'h80, "R9 peer force from m0");
    wr_ctrl(0, 8'h00, "R9 release m0");
    wr_ctrl(1, 8'h80, "R9 peer force from m1");
    wr_ctrl(1, 8'hC0, "R9 both from m1");
    wr_ctrl(1, 8'h00, "R9 release m1");
    wr_ie(1, 8'h00, "R3 unmask m1");

    @(negedge clk); @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule